// File: doc/BRIEF.md
# Bit-Sliced AES State Rotation Array

This block stores one 128-bit AES state as eight bit planes. Plane k holds bit k of every state byte, laid out as a 4x4 grid. Each row of each plane lives in its own shift track. A track holds the four visible cells of the row plus a few spare cells that copy cells from the far end of the row. With these spares, a cyclic row rotation is done by shifting the track alone, and no cell is ever written back from one end of the row to the other.

A controller outside the block loads a whole state in parallel, or changes single bytes through a byte write port. It then issues a rotation command that applies the AES ShiftRows permutation to all rows in one cycle. The 128-bit readout always shows the visible cells of every track.

After each rotation the block spends one restore cycle copying the visible cells back into the spare cells. A rotation requested during that cycle is held and carried out one cycle later.

Top module: `aes_sliced_state`

## Requirements
- R1: When `loadValid` is high at a clock edge, `stateOut` equals `loadData` from the next cycle on. State byte (row r, column c) is bits [(4c+r)*8 +: 8], and bit k of that byte is held in bit plane k.
- R2: When `wrEn` is high at an edge with no load or executed rotation, byte (`wrRow`,`wrCol`) becomes `wrByte` in the next cycle. All other bytes keep their values.
- R3: An executed rotation makes byte (r,c) of `stateOut` equal the earlier byte (r,(c+r) mod 4) in the cycle after the edge. Row 0 is left unchanged.
- R4: `shiftDone` is high for exactly the one cycle that follows the edge at which a rotation executes, and is low otherwise.
- R5: Bytes written by a load or by the byte port are copied into the spare cells. A rotation after any mix of writes, including a write in the restore cycle, gives the R3 result. Four rotations in a row restore the original state.
- R6: A `shiftCmd` seen at the edge right after an executed rotation (the restore cycle) is executed at the following edge, and its `shiftDone` comes one cycle after that.
- R7: Load has priority over rotation and write. A rotation request that meets a load is dropped, with no `shiftDone`. A byte write that meets an executed rotation is dropped.
- R8: The restore cycle leaves `stateOut` unchanged.
- R9: After reset, `stateOut` is all zeros and `shiftDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadValid | input | 1 | Parallel load strobe |
| loadData | input | 128 | State to load (byte mapping as in R1) |
| wrEn | input | 1 | Single-byte write strobe |
| wrRow | input | 2 | Row of the byte to write |
| wrCol | input | 2 | Column of the byte to write |
| wrByte | input | 8 | Byte value to write |
| shiftCmd | input | 1 | Rotation request |
| stateOut | output | 128 | Visible state (byte mapping as in R1) |
| shiftDone | output | 1 | Pulse one cycle after an executed rotation |

## Verification
Every result of this block is due one cycle after the edge that causes it. A load, a byte write or a rotation shows on `stateOut` right after that edge, and `shiftDone` rises at the same time. The restore cycle follows one edge later, and a deferred rotation lands two edges after its first request.

The bench drives inputs well before an edge and samples 1 ns after it. It checks the rotated state and the `shiftDone` pulse in that first cycle, then checks the following cycle to confirm that the readout did not move and the pulse fell. For the deferred case it walks three edges one at a time.

// File: rtl/aes_slice_pkg.sv
`timescale 1ns/1ps
package aes_slice_pkg;

  localparam int unsigned ROWS  = 4;
  localparam int unsigned COLS  = 4;
  localparam int unsigned COL_W = $clog2(COLS);
  localparam int unsigned ROW_W = $clog2(ROWS);

  typedef struct packed {
    logic load;
    logic write;
    logic shift;
    logic refresh;
  } ctrlStrobes_t;

  // Rows that rotate left by at most half a row shift left and keep spares
  // above the window; longer rotations are done as a short right shift.
  function automatic int unsigned padHi(int unsigned row);
    return (row <= COLS / 2) ? row : 0;
  endfunction

  function automatic int unsigned padLo(int unsigned row);
    return (row > COLS / 2) ? (COLS - row) : 0;
  endfunction

endpackage

// File: rtl/sst_track.sv
`timescale 1ns/1ps
module sst_track
  import aes_slice_pkg::*;
#(
  parameter int unsigned NLO = 0,
  parameter int unsigned NHI = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [COLS-1:0]  loadBits,
  input  logic             wrEn,
  input  logic [COL_W-1:0] wrCol,
  input  logic             wrBit,
  input  logic             shiftEn,
  input  logic             refreshEn,
  output logic [COLS-1:0]  window
);

  localparam int unsigned LEN = COLS + NLO + NHI;

  logic [LEN-1:0] cells;
  logic [LEN-1:0] cellsNxt;

  always_comb begin
    cellsNxt = cells;

    // Restore spares from the visible window.
    if (refreshEn) begin
      for (int j = 0; j < NHI; j++) cellsNxt[NLO + COLS + j] = cells[NLO + j];
      for (int j = 0; j < NLO; j++) cellsNxt[j] = cells[COLS + j];
    end

    // Pure shift: spares slide into the window.
    if (shiftEn) begin
      if (NHI > 0) begin
        for (int i = 0; i < LEN - NHI; i++) cellsNxt[i] = cells[i + NHI];
        for (int i = LEN - NHI; i < LEN; i++) cellsNxt[i] = 1'b0;
      end else if (NLO > 0) begin
        for (int i = NLO; i < LEN; i++) cellsNxt[i] = cells[i - NLO];
        for (int i = 0; i < NLO; i++) cellsNxt[i] = 1'b0;
      end
    end

    // Byte port write with its spare copy in the same operation.
    if (wrEn) begin
      for (int c = 0; c < COLS; c++) begin
        if (int'(wrCol) == c) begin
          cellsNxt[NLO + c] = wrBit;
          if (c < NHI) cellsNxt[NLO + COLS + c] = wrBit;
          if (c >= COLS - NLO) cellsNxt[c - (COLS - NLO)] = wrBit;
        end
      end
    end

    if (loadEn) begin
      for (int c = 0; c < COLS; c++) begin
        cellsNxt[NLO + c] = loadBits[c];
        if (c < NHI) cellsNxt[NLO + COLS + c] = loadBits[c];
        if (c >= COLS - NLO) cellsNxt[c - (COLS - NLO)] = loadBits[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cells <= '0;
    else       cells <= cellsNxt;
  end

  assign window = cells[NLO +: COLS];

endmodule

// File: rtl/sst_datapath.sv
`timescale 1ns/1ps
module sst_datapath
  import aes_slice_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [ROWS*COLS*BYTE_W-1:0] loadData,
  input  logic [ROW_W-1:0]            wrRow,
  input  logic [COL_W-1:0]            wrCol,
  input  logic [BYTE_W-1:0]           wrByte,
  output logic [ROWS*COLS*BYTE_W-1:0] stateOut
);

  for (genvar k = 0; k < BYTE_W; k++) begin : g_plane
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] loadBits;
      logic [COLS-1:0] window;
      logic            rowWr;

      for (genvar c = 0; c < COLS; c++) begin : g_col
        assign loadBits[c] = loadData[(c*ROWS + r)*BYTE_W + k];
        assign stateOut[(c*ROWS + r)*BYTE_W + k] = window[c];
      end

      assign rowWr = strobes.write && (int'(wrRow) == r);

      sst_track #(
        .NLO(padLo(r)),
        .NHI(padHi(r))
      ) u_track (
        .clk      (clk),
        .rstN     (rstN),
        .loadEn   (strobes.load),
        .loadBits (loadBits),
        .wrEn     (rowWr),
        .wrCol    (wrCol),
        .wrBit    (wrByte[k]),
        .shiftEn  (strobes.shift),
        .refreshEn(strobes.refresh),
        .window   (window)
      );
    end
  end

endmodule

// File: rtl/sst_control.sv
`timescale 1ns/1ps
module sst_control
  import aes_slice_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadValid,
  input  logic         wrEn,
  input  logic         shiftCmd,
  output ctrlStrobes_t strobes,
  output logic         shiftDone
);

  logic refreshDue;
  logic pendShift;
  logic shiftReq;

  assign shiftReq = shiftCmd || pendShift;

  always_comb begin
    strobes.load    = loadValid;
    strobes.shift   = shiftReq && !refreshDue && !loadValid;
    strobes.write   = wrEn && !loadValid && !strobes.shift;
    strobes.refresh = refreshDue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshDue <= 1'b0;
      pendShift  <= 1'b0;
      shiftDone  <= 1'b0;
    end else begin
      refreshDue <= strobes.shift;
      pendShift  <= shiftReq && refreshDue && !loadValid;
      shiftDone  <= strobes.shift;
    end
  end

endmodule

// File: rtl/aes_sliced_state.sv
`timescale 1ns/1ps
module aes_sliced_state
  import aes_slice_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadValid,
  input  logic [ROWS*COLS*BYTE_W-1:0] loadData,
  input  logic                        wrEn,
  input  logic [ROW_W-1:0]            wrRow,
  input  logic [COL_W-1:0]            wrCol,
  input  logic [BYTE_W-1:0]           wrByte,
  input  logic                        shiftCmd,
  output logic [ROWS*COLS*BYTE_W-1:0] stateOut,
  output logic                        shiftDone
);

  ctrlStrobes_t strobes;

  sst_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadValid(loadValid),
    .wrEn     (wrEn),
    .shiftCmd (shiftCmd),
    .strobes  (strobes),
    .shiftDone(shiftDone)
  );

  sst_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadData(loadData),
    .wrRow   (wrRow),
    .wrCol   (wrCol),
    .wrByte  (wrByte),
    .stateOut(stateOut)
  );

endmodule

// File: rtl/aes_sliced_state_chk.sv
`timescale 1ns/1ps
module aes_sliced_state_chk
  import aes_slice_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        loadValid,
  input logic [ROWS*COLS*BYTE_W-1:0] loadData,
  input logic [ROW_W-1:0]            wrRow,
  input logic [COL_W-1:0]            wrCol,
  input logic [BYTE_W-1:0]           wrByte,
  input logic [ROWS*COLS*BYTE_W-1:0] stateOut,
  input logic                        shiftDone,
  input ctrlStrobes_t                strobes
);

  localparam int unsigned DATA_W = ROWS*COLS*BYTE_W;

  function automatic logic [DATA_W-1:0] rotRows(logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] o;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        o[(c*ROWS + r)*BYTE_W +: BYTE_W] = s[(((c + r) % COLS)*ROWS + r)*BYTE_W +: BYTE_W];
    return o;
  endfunction

  logic [ROW_W+COL_W-1:0] capIdx;
  logic [BYTE_W-1:0]      capByte;

  always_ff @(posedge clk) begin
    capIdx  <= {wrCol, wrRow};
    capByte <= wrByte;
  end

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> stateOut == $past(loadData));                        // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.write |=> stateOut[capIdx*BYTE_W +: BYTE_W] == capByte);   // R2

  AST_ROTATE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |-> stateOut == rotRows($past(stateOut)));               // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |=> !shiftDone);                                         // R4

  AST_STROBE_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.shift, strobes.write}));           // R7

  AST_RESTORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.refresh && !strobes.load && !strobes.write) |=> $stable(stateOut)); // R8

endmodule

bind aes_sliced_state aes_sliced_state_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadValid(loadValid),
  .loadData (loadData),
  .wrRow    (wrRow),
  .wrCol    (wrCol),
  .wrByte   (wrByte),
  .stateOut (stateOut),
  .shiftDone(shiftDone),
  .strobes  (strobes)
);

// File: tb/sim_aes_sliced_state.sv
`timescale 1ns/1ps
module sim_aes_sliced_state;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadValid = 1'b0;
  logic [127:0] loadData = '0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrRow = '0;
  logic [1:0]   wrCol = '0;
  logic [7:0]   wrByte = '0;
  logic         shiftCmd = 1'b0;
  logic [127:0] stateOut;
  logic         shiftDone;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  aes_sliced_state u0 (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadData(loadData),
    .wrEn(wrEn), .wrRow(wrRow), .wrCol(wrCol), .wrByte(wrByte),
    .shiftCmd(shiftCmd), .stateOut(stateOut), .shiftDone(shiftDone)
  );

  localparam logic [127:0] TBL [6] = '{
    128'h000102030405060708090a0b0c0d0e0f,
    128'h00112233445566778899aabbccddeeff,
    128'hffffffffffffffffffffffffffffffff,
    128'h80000000000000000000000000000001,
    128'h0123456789abcdeffedcba9876543210,
    128'h5a5aa5a55a5aa5a5c3c33c3c96966969
  };

  function automatic logic [127:0] refRot(logic [127:0] s);
    logic [127:0] o;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        o[(c*4 + r)*8 +: 8] = s[(((c + r) % 4)*4 + r)*8 +: 8];
    return o;
  endfunction

  function automatic logic [127:0] refPut(logic [127:0] s, int r, int c, logic [7:0] b);
    logic [127:0] o = s;
    o[(c*4 + r)*8 +: 8] = b;
    return o;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doLoad(logic [127:0] v);
    loadValid = 1'b1; loadData = v;
    tick();
    loadValid = 1'b0;
  endtask

  task automatic doWrite(int r, int c, logic [7:0] b);
    wrEn = 1'b1; wrRow = 2'(r); wrCol = 2'(c); wrByte = b;
    tick();
    wrEn = 1'b0;
  endtask

  // One rotation plus its restore cycle, fully checked.
  task automatic rotChk(inout logic [127:0] model);
    shiftCmd = 1'b1;
    tick();
    shiftCmd = 1'b0;
    model = refRot(model);
    chk("R3 rotation", stateOut, model);
    chk("R4 done high", {127'd0, shiftDone}, 128'd1);
    tick();
    chk("R8 restore stable", stateOut, model);
    chk("R4 done low", {127'd0, shiftDone}, 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] model;
    logic [127:0] orig;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R9 reset state", stateOut, '0);
    chk("R9 reset done", {127'd0, shiftDone}, '0);

    // Vector table: load then several rounds.
    for (int t = 0; t < 6; t++) begin
      doLoad(TBL[t]);
      chk("R1 load", stateOut, TBL[t]);
      model = TBL[t];
      for (int k = 0; k < 4; k++) rotChk(model);
      chk("R5 four rounds identity", stateOut, TBL[t]);
    end

    // Random states, several rounds in a row.
    for (int t = 0; t < 12; t++) begin
      orig = {$urandom, $urandom, $urandom, $urandom};
      doLoad(orig);
      chk("R1 load random", stateOut, orig);
      model = orig;
      for (int k = 0; k < 3; k++) rotChk(model);
    end

    // R2: byte writes leave other bytes alone.
    model = TBL[1];
    doLoad(model);
    doWrite(2, 3, 8'hc7);
    model = refPut(model, 2, 3, 8'hc7);
    chk("R2 write byte", stateOut, model);
    doWrite(0, 0, 8'h3e);
    model = refPut(model, 0, 0, 8'h3e);
    chk("R2 write byte corner", stateOut, model);

    // R5: writes into cells that have spare copies, then rotate.
    doWrite(3, 3, 8'ha1);
    doWrite(1, 0, 8'hb2);
    doWrite(2, 1, 8'hd4);
    doWrite(2, 0, 8'he5);
    model = refPut(model, 3, 3, 8'ha1);
    model = refPut(model, 1, 0, 8'hb2);
    model = refPut(model, 2, 1, 8'hd4);
    model = refPut(model, 2, 0, 8'he5);
    chk("R2 multi write", stateOut, model);
    rotChk(model);

    // R5: write issued in the restore cycle, then rotate.
    shiftCmd = 1'b1;
    tick();
    shiftCmd = 1'b0;
    model = refRot(model);
    chk("R3 rotation before restore write", stateOut, model);
    wrEn = 1'b1; wrRow = 2'd2; wrCol = 2'd0; wrByte = 8'h6b;
    tick();
    wrEn = 1'b0;
    model = refPut(model, 2, 0, 8'h6b);
    chk("R5 write in restore cycle", stateOut, model);
    wrEn = 1'b1; wrRow = 2'd3; wrCol = 2'd3; wrByte = 8'h17;
    tick();
    wrEn = 1'b0;
    model = refPut(model, 3, 3, 8'h17);
    rotChk(model);
    chk("R5 rotation after restore write", stateOut, model);

    // R6: request held across the restore cycle.
    orig = TBL[4];
    doLoad(orig);
    model = orig;
    shiftCmd = 1'b1;
    tick();
    model = refRot(model);
    chk("R6 first rotation", stateOut, model);
    tick();
    shiftCmd = 1'b0;
    chk("R6 deferred not yet", stateOut, model);
    chk("R6 done low in restore", {127'd0, shiftDone}, '0);
    tick();
    model = refRot(model);
    chk("R6 deferred rotation", stateOut, model);
    chk("R6 deferred done", {127'd0, shiftDone}, 128'd1);
    tick();
    chk("R6 done low after", {127'd0, shiftDone}, '0);
    chk("R6 stable after", stateOut, model);

    // R7: load beats rotation.
    shiftCmd = 1'b1; loadValid = 1'b1; loadData = TBL[5];
    tick();
    shiftCmd = 1'b0; loadValid = 1'b0;
    chk("R7 load over rotation", stateOut, TBL[5]);
    chk("R7 no done on dropped rotation", {127'd0, shiftDone}, '0);
    tick();
    chk("R7 still loaded", stateOut, TBL[5]);
    chk("R7 no late done", {127'd0, shiftDone}, '0);

    // R7: rotation beats byte write.
    model = TBL[5];
    shiftCmd = 1'b1; wrEn = 1'b1; wrRow = 2'd1; wrCol = 2'd2; wrByte = 8'h99;
    tick();
    shiftCmd = 1'b0; wrEn = 1'b0;
    model = refRot(model);
    chk("R7 write dropped under rotation", stateOut, model);
    tick();
    chk("R7 write stays dropped", stateOut, model);

    // R7: load beats byte write.
    loadValid = 1'b1; loadData = TBL[0]; wrEn = 1'b1; wrRow = 2'd0; wrCol = 2'd0; wrByte = 8'hff;
    tick();
    loadValid = 1'b0; wrEn = 1'b0;
    chk("R7 load over write", stateOut, TBL[0]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule